// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Timer Channel

This block is a 16-bit up-counting timer with one edge-aligned PWM channel. Software drives it over an 8-bit register bus. The counter runs from zero up to a programmable modulo and wraps back to zero. A modulo of zero selects a free-running count over the full 16-bit range. Each wrap raises an overflow flag. The channel compares the counter against an active compare value: it drives the PWM output and raises a match flag. Each flag has its own interrupt enable and its own interrupt request output.

The compare value is 16 bits wide and arrives as two bytes. The high byte is held back until the low byte completes the pair. While the counter runs, the completed pair waits in a holding register. It is copied into the active compare register only on the step into the top count, so a duty change never tears a PWM period. While the counter is stopped, a completed pair goes straight to the active register. The channel interrupt enable has no part in this transfer. Each flag clears only when software reads it while it is set and then writes zero to it. A match that lands after that read keeps the flag set.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset every register reads zero, the counter is stopped at 0, and `pwm_out`, `ovf_irq` and `chan_irq` are low.
- R2: When the clock field (address 0, bits 1:0) is nonzero, the counter steps by one each cycle and wraps to 0 after reaching the top count. The top count is the modulo, or 0xFFFF when the modulo is zero. When the clock field is zero the counter holds its value.
- R3: The overflow flag (address 0, bit 7) becomes set on the edge where the counter wraps to 0. `ovf_irq` is high while that flag and the overflow enable (address 0, bit 6) are both set.
- R4: While the counter runs, a completed compare pair reaches the active compare register on the edge where the counter steps from top minus one to top, and on no other edge.
- R5: A high-byte write (address 6) alone never completes a pair. A low-byte write (address 7) completes a pair only after a high-byte write, and is otherwise ignored.
- R6: With the modulo at zero, the pending compare value loads when the counter steps from 0xFFFE to 0xFFFF.
- R7: The channel interrupt enable (address 5, bit 6) does not change the cycle in which a pending compare value is loaded.
- R8: While the counter is stopped, the low-byte write that completes a pair loads the active compare register on that write's clock edge.
- R9: With the PWM mode bit (address 5, bit 5) set and the high-true bit (address 5, bit 3) set, `pwm_out` is high exactly while the counter is below the active compare value. A compare value above the modulo therefore gives 100% duty and a value of 0 gives 0% duty. A clear high-true bit inverts the output, and a clear mode bit holds the output low.
- R10: The channel flag (address 5, bit 7) becomes set on the edge that leaves a running count equal to the active compare value. `chan_irq` is high while that flag and the channel interrupt enable are both set.
- R11: A flag is cleared by a write of 0 to its bit 7 only if a read of its register with the flag set came earlier. A write without such a read leaves the flag set.
- R12: A match or wrap that sets the flag after the arming read, up to and including the clearing write's cycle, keeps the flag set.
- R13: Register map: 0 is timer control, 1 and 2 are counter high and low (read only; writes are ignored), 3 and 4 are modulo high and low, 5 is channel control, and 6 and 7 are compare high and low. Reading 6 and 7 returns the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | PWM output |
| ovf_irq | output | 1 | Overflow interrupt request |
| chan_irq | output | 1 | Channel interrupt request |

## Verification
Register writes, flag changes, counter steps and compare loads all show up at the negedge after the rising edge that makes them, one cycle after a stimulus. `pwm_out` and `bus_rdata` follow the registered state combinationally within that same half cycle. The bench drives each strobe for exactly one rising edge. It then samples at the following negedge by setting `bus_addr` alone, which has no side effects, and reading `bus_rdata`. Load timing is checked by watching for the first negedge where the active compare value differs and requiring the counter to read the top count there. Duty is checked by counting high samples over exactly one period once the output has settled.

// File: rtl/pwm_timer_pkg.sv
// Package: shared register addresses and bit positions for the PWM timer.
// Assumes an 8-bit register bus with a 3-bit address.
package pwm_timer_pkg;
    typedef enum logic [2:0] {
        A_TCTL  = 3'd0,
        A_CNTH  = 3'd1,
        A_CNTL  = 3'd2,
        A_MODH  = 3'd3,
        A_MODL  = 3'd4,
        A_CHCTL = 3'd5,
        A_CMPH  = 3'd6,
        A_CMPL  = 3'd7
    } reg_addr_e;

    localparam int FLAG_BIT = 7;
    localparam int IEN_BIT  = 6;
    localparam int MODE_BIT = 5;
    localparam int POL_BIT  = 3;
    localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/pwm_counter.sv
// Module: up-counter with modulo wrap.
// Counts 0..top while run is high and holds otherwise. top is the modulo,
// or all ones when the modulo is zero. Flags the wrap edge and the step
// into top (the buffered compare load point).
module pwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] modv,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] top,
    output logic          wrap,
    output logic          load_pt
);
    // Top count select: zero modulo means free-running.
    assign top     = (modv == '0) ? '1 : modv;
    assign wrap    = run && (cnt >= top);
    assign load_pt = run && (cnt == top - 1'b1);

    // Counter register: step or wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_cmp_buf.sv
// Module: byte-coherent compare buffer and active compare register.
// A high-byte write arms the pair and a following low-byte write completes
// it. Running: the pair waits until load_pt. Stopped: it loads at once.
module pwm_cmp_buf #(
    parameter int DW = 8,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [DW-1:0] wdata,
    input  logic          run,
    input  logic          load_pt,
    output logic [CW-1:0] cmp_act,
    output logic          pend
);
    logic [DW-1:0] hi_hold;
    logic          hi_seen;
    logic [CW-1:0] pair_q;

    // Buffer and active register update: boundary load first, then byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_hold <= '0;
            hi_seen <= 1'b0;
            pair_q  <= '0;
            pend    <= 1'b0;
            cmp_act <= '0;
        end else begin
            if (load_pt && pend) begin
                cmp_act <= pair_q;
                pend    <= 1'b0;
            end
            if (wr_hi) begin
                hi_hold <= wdata;
                hi_seen <= 1'b1;
            end else if (wr_lo && hi_seen) begin
                hi_seen <= 1'b0;
                if (run) begin
                    pair_q <= {hi_hold, wdata};
                    pend   <= 1'b1;
                end else begin
                    cmp_act <= {hi_hold, wdata};
                    pend    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pwm_flag.sv
// Module: event flag with read-then-write-zero clearing.
// A read while set arms the clear. A later write with wr_bit low clears the
// flag if still armed. A set event wins and disarms.
module pwm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_evt,
    input  logic wr_evt,
    input  logic wr_bit,
    output logic flag
);
    logic armed;

    // Flag and arm state update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (set_evt) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (wr_evt) begin
            if (armed && !wr_bit)
                flag <= 1'b0;
            armed <= 1'b0;
        end else if (rd_evt && flag) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_timer_ch.sv
// Module: top of the buffered edge-aligned PWM timer channel.
// Decodes the 8-bit register bus, holds control and modulo registers, and
// ties together the counter, compare buffer and flags. Assumes DW is 8, so
// the control layouts fill one byte.
module pwm_timer_ch
    import pwm_timer_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          pwm_out,
    output logic          ovf_irq,
    output logic          chan_irq
);
    logic [1:0]           clk_sel;
    logic                 toie, ch_ie, ch_mode, ch_pol;
    logic [CW-1:0]        mod_q, cnt_v, top_v, cmp_act;
    logic                 run, wrap, load_pt, cmp_pend;
    logic [NUM_FLAGS-1:0] flag_set, flag_q;

    assign run = |clk_sel;

    // Control and modulo register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel <= '0;
            toie    <= 1'b0;
            ch_ie   <= 1'b0;
            ch_mode <= 1'b0;
            ch_pol  <= 1'b0;
            mod_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_TCTL: begin
                    toie    <= bus_wdata[IEN_BIT];
                    clk_sel <= bus_wdata[1:0];
                end
                A_MODH: mod_q[CW-1:DW] <= bus_wdata;
                A_MODL: mod_q[DW-1:0]  <= bus_wdata;
                A_CHCTL: begin
                    ch_ie   <= bus_wdata[IEN_BIT];
                    ch_mode <= bus_wdata[MODE_BIT];
                    ch_pol  <= bus_wdata[POL_BIT];
                end
                default: ;
            endcase
        end
    end

    pwm_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .modv(mod_q),
        .cnt(cnt_v), .top(top_v), .wrap(wrap), .load_pt(load_pt)
    );

    pwm_cmp_buf #(.DW(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(bus_wr && bus_addr == A_CMPH),
        .wr_lo(bus_wr && bus_addr == A_CMPL),
        .wdata(bus_wdata), .run(run), .load_pt(load_pt),
        .cmp_act(cmp_act), .pend(cmp_pend)
    );

    // Flag set events: index 0 is overflow, index 1 is channel match.
    assign flag_set[0] = wrap;
    assign flag_set[1] = run && (cnt_v == cmp_act);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam logic [2:0] FA = (i == 0) ? 3'(A_TCTL) : 3'(A_CHCTL);
        pwm_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_evt(flag_set[i]),
            .rd_evt(bus_rd && bus_addr == FA),
            .wr_evt(bus_wr && bus_addr == FA),
            .wr_bit(bus_wdata[FLAG_BIT]), .flag(flag_q[i])
        );
    end

    // PWM output: high-true below compare, polarity and mode applied.
    assign pwm_out  = ch_mode && ((cnt_v < cmp_act) == ch_pol);
    assign ovf_irq  = flag_q[0] && toie;
    assign chan_irq = flag_q[1] && ch_ie;

    // Register read multiplexer, driven from the address alone.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TCTL: begin
                bus_rdata[FLAG_BIT] = flag_q[0];
                bus_rdata[IEN_BIT]  = toie;
                bus_rdata[1:0]      = clk_sel;
            end
            A_CNTH:  bus_rdata = cnt_v[CW-1:DW];
            A_CNTL:  bus_rdata = cnt_v[DW-1:0];
            A_MODH:  bus_rdata = mod_q[CW-1:DW];
            A_MODL:  bus_rdata = mod_q[DW-1:0];
            A_CHCTL: begin
                bus_rdata[FLAG_BIT] = flag_q[1];
                bus_rdata[IEN_BIT]  = ch_ie;
                bus_rdata[MODE_BIT] = ch_mode;
                bus_rdata[POL_BIT]  = ch_pol;
            end
            A_CMPH:  bus_rdata = cmp_act[CW-1:DW];
            default: bus_rdata = cmp_act[DW-1:0];
        endcase
    end
endmodule

// File: rtl/pwm_timer_chk.sv
// Module: assertion checker for pwm_timer_ch, attached by bind below.
// Watches counter, compare, flag and bus signals; all properties are
// disabled during reset.
module pwm_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic          wdata_b7,
    input logic          run,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] top,
    input logic [CW-1:0] cmp_act,
    input logic          pend,
    input logic          tof,
    input logic          chf,
    input logic          ch_mode,
    input logic          ch_pol,
    input logic          pwm_out
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt < top) |=> cnt == $past(cnt) + 1'b1);  // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));  // R2
    AST_TOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tof) |-> cnt == '0);  // R3
    AST_LOAD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && cmp_act != $past(cmp_act)) |-> $past(cnt) == $past(top) - 1'b1);  // R4
    AST_NO_LOAD_UNPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(pend)) |-> cmp_act == $past(cmp_act));  // R5
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode && ch_pol && cmp_act == '0) |-> !pwm_out);  // R9
    AST_CHF_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chf) |-> $past(cnt) == $past(cmp_act));  // R10
    AST_CHF_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chf) |-> $past(bus_wr && bus_addr == 3'd5 && !wdata_b7));  // R11
endmodule

bind pwm_timer_ch pwm_timer_chk #(.CW(2 * DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wdata_b7(bus_wdata[7]), .run(run), .cnt(cnt_v), .top(top_v),
    .cmp_act(cmp_act), .pend(cmp_pend), .tof(flag_q[0]), .chf(flag_q[1]),
    .ch_mode(ch_mode), .ch_pol(ch_pol), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_timer_ch.sv
// Bench for pwm_timer_ch: duty vector table, then directed tests.
module sim_pwm_timer_ch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       pwm_out, ovf_irq, chan_irq;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_timer_ch u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .ovf_irq(ovf_irq), .chan_irq(chan_irq)
    );

    // {modulo, compare, channel control, expected high samples per period}
    localparam logic [55:0] VECS [8] = '{
        {16'd9, 16'd4,  8'h28, 16'd4},
        {16'd9, 16'd0,  8'h28, 16'd0},
        {16'd9, 16'd12, 8'h28, 16'd10},
        {16'd9, 16'd9,  8'h28, 16'd9},
        {16'd9, 16'd4,  8'h20, 16'd6},
        {16'd3, 16'd1,  8'h28, 16'd1},
        {16'd5, 16'd6,  8'h28, 16'd6},
        {16'd9, 16'd4,  8'h08, 16'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic peek16(input logic [2:0] hi, output logic [15:0] d);
        logic [7:0] h, l;
        peek(hi, h);
        peek(hi + 3'd1, l);
        d = {h, l};
    endtask

    // Program modulo 9, compare 1 while stopped, then a pending value while running.
    task automatic load_check(input logic [7:0] ctl, input logic [15:0] val, input string tag);
        logic [15:0] a, c;
        bit seen = 1'b0;
        wr(3'd0, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'd9); wr(3'd5, ctl);
        wr(3'd6, 8'h00); wr(3'd7, 8'h01);
        wr(3'd0, 8'h01);
        wr(3'd6, val[15:8]); wr(3'd7, val[7:0]);
        for (int i = 0; i < 30 && !seen; i++) begin
            peek16(3'd6, a);
            peek16(3'd1, c);
            if (a != 16'd1) begin
                seen = 1'b1;
                chk({tag, " load counter"}, c, 16'd9);
                chk({tag, " load value"}, a, val);
            end
            @(negedge clk);
        end
        chk({tag, " load seen"}, seen, 1);
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        logic [15:0] c;
        for (int i = 0; i < 40; i++) begin
            peek16(3'd1, c);
            if (c == v) return;
            @(negedge clk);
        end
        chk("R2 wait for count", c, v);
    endtask

    task automatic wait_flag(input logic [2:0] a, input string tag);
        logic [7:0] d;
        for (int i = 0; i < 40; i++) begin
            peek(a, d);
            if (d[7]) return;
            @(negedge clk);
        end
        chk(tag, d[7], 1);
    endtask

    initial begin
        logic [7:0]  d;
        logic [15:0] c, a, prev;
        int          hi_cnt;
        bit          seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(3'd0, d); chk("R1 timer ctrl", d, 0);
        peek(3'd5, d); chk("R1 channel ctrl", d, 0);
        peek16(3'd6, a); chk("R1 compare", a, 0);
        peek16(3'd1, c); chk("R1 counter", c, 0);
        chk("R1 outputs", {pwm_out, ovf_irq, chan_irq}, 0);

        // R9 / R8 / R13: duty vectors
        for (int v = 0; v < 8; v++) begin
            logic [15:0] m, cv, ex;
            logic [7:0]  ctl;
            {m, cv, ctl, ex} = VECS[v];
            wr(3'd0, 8'h00); wr(3'd3, m[15:8]); wr(3'd4, m[7:0]);
            wr(3'd5, ctl); wr(3'd6, cv[15:8]); wr(3'd7, cv[7:0]);
            peek16(3'd6, a); chk("R8 direct load while stopped", a, cv);
            peek16(3'd3, a); chk("R13 modulo readback", a, m);
            wr(3'd0, 8'h01);
            repeat (2 * (m + 1)) @(negedge clk);
            hi_cnt = 0;
            for (int k = 0; k <= int'(m); k++) begin
                if (pwm_out) hi_cnt++;
                @(negedge clk);
            end
            chk($sformatf("R9 duty vector %0d", v), hi_cnt, ex);
        end

        // R2: counter steps and wraps at modulo 9
        wr(3'd0, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'd9); wr(3'd0, 8'h01);
        peek16(3'd1, prev);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            peek16(3'd1, c);
            chk("R2 counter step", c, (prev == 16'd9) ? 16'd0 : prev + 16'd1);
            prev = c;
        end
        wr(3'd0, 8'h00);
        peek16(3'd1, prev);
        repeat (3) @(negedge clk);
        peek16(3'd1, c); chk("R2 counter holds when stopped", c, prev);
        wr(3'd2, 8'hAA);
        peek16(3'd1, c); chk("R13 counter write ignored", c, prev);

        // R8: high byte alone leaves active value; low completes at once
        wr(3'd6, 8'h00);
        peek16(3'd6, a); chk("R8 high byte alone", a, 16'd4);
        wr(3'd7, 8'h03);
        peek16(3'd6, a); chk("R8 completed pair", a, 16'd3);

        // R4 / R7: load at step into top, independent of interrupt enable
        load_check(8'h28, 16'd7, "R4 R7 ien=0");
        load_check(8'h68, 16'd7, "R4 R7 ien=1");

        // R5: unpaired bytes
        wr(3'd6, 8'h00);
        repeat (25) @(negedge clk);
        peek16(3'd6, a); chk("R5 high byte only", a, 16'd7);
        wr(3'd7, 8'h02);
        repeat (12) @(negedge clk);
        peek16(3'd6, a); chk("R5 pair completed later", a, 16'd2);
        wr(3'd7, 8'h05);
        repeat (25) @(negedge clk);
        peek16(3'd6, a); chk("R5 low byte without high", a, 16'd2);

        // R3 / R11: overflow flag, interrupt and clear
        wr(3'd0, 8'h40);
        rd(3'd0); wr(3'd0, 8'h40);
        peek(3'd0, d); chk("R11 overflow flag cleared", d[7], 0);
        chk("R3 ovf_irq low after clear", ovf_irq, 0);
        wr(3'd0, 8'h41);
        wait_flag(3'd0, "R3 overflow flag sets");
        peek16(3'd1, c); chk("R3 flag seen with counter at 0", c, 0);
        chk("R3 ovf_irq with enable", ovf_irq, 1);
        wr(3'd0, 8'h01);
        chk("R3 ovf_irq masked", ovf_irq, 0);

        // R10 / R11: channel flag on match and clear sequence
        wr(3'd0, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'h04); wr(3'd5, 8'h68);
        rd(3'd5); wr(3'd5, 8'h68);
        wr(3'd0, 8'h01);
        wait_flag(3'd5, "R10 channel flag sets");
        peek16(3'd1, c); chk("R10 flag seen after match", c, 16'd5);
        chk("R10 chan_irq", chan_irq, 1);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'h68);
        peek(3'd5, d); chk("R11 write without read", d[7], 1);
        rd(3'd5); wr(3'd5, 8'h68);
        peek(3'd5, d); chk("R11 read then write clears", d[7], 0);
        chk("R11 chan_irq cleared", chan_irq, 0);

        // R12: match between read and write keeps the flag
        wr(3'd0, 8'h01);
        wait_flag(3'd5, "R12 flag set again");
        wait_cnt(16'd3);
        rd(3'd5);
        @(negedge clk);
        wr(3'd5, 8'h68);
        peek(3'd5, d); chk("R12 match after read keeps flag", d[7], 1);
        wait_cnt(16'd6);
        rd(3'd5); wr(3'd5, 8'h68);
        peek(3'd5, d); chk("R12 clean sequence clears", d[7], 0);

        // R6: free-running load at 0xFFFE -> 0xFFFF
        wr(3'd0, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h01);
        wr(3'd6, 8'h12); wr(3'd7, 8'h34);
        seen = 1'b0;
        for (int i = 0; i < 70000 && !seen; i++) begin
            peek16(3'd6, a);
            peek16(3'd1, c);
            if (a != 16'd4) begin
                seen = 1'b1;
                chk("R6 free-running load counter", c, 16'hFFFF);
                chk("R6 free-running load value", a, 16'h1234);
            end
            @(negedge clk);
        end
        chk("R6 free-running load seen", seen, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule